// File: doc/BRIEF.md
# Overclock Recovery Watchdog

This block guards a clock generator against a hung system after overclocking. When armed, it counts down a host-programmed number of timebase ticks. Every valid host transaction restarts the count, and so does a write of the count value. If neither arrives before the count runs out, the block raises a sticky alarm. It then replaces the active frequency-select code with a stored safe code, so the clock falls back to a setting known to work.

A prescaler divides the system clock into ticks. A select input picks between a slow period, standing for 580 ms, and a fast period, standing for 2 ms. Both periods are parameters given in system clocks, so a simulation can scale them down. An 8-bit value N gives a timeout of N+1 ticks. The reset value FFh therefore gives 256 slow ticks, about 148 seconds.

The safe code uses the same encoding as the active frequency-select code. Clearing the enable input is the only way to drop the alarm, and it restores normal frequency selection.

Top module: `ocwd_top`

## Requirements
- R1: After reset, `alarm` is 0 and `eff_code` equals `active_code`.
- R2: While `wd_enable` is 0, the block never raises `alarm`, however long it runs.
- R3: With `tb_sel`=0, a restart at clock edge k with count value N sets `alarm` at edge k+(N+1)×SLOW_TICK_CLKS, and not at the edge before.
- R4: With `tb_sel`=1, the same timing holds with FAST_TICK_CLKS as the tick period.
- R5: A `service` pulse before expiry restarts the full timeout, measured from the edge that samples the pulse.
- R6: A `count_wr` pulse restarts the timeout using the `count_value` present with the pulse.
- R7: While `alarm` is 1, `eff_code` equals `safe_code` whatever `active_code` is.
- R8: `alarm` is sticky: `service` and `count_wr` pulses do not clear it while `wd_enable` stays 1.
- R9: Driving `wd_enable` to 0 clears `alarm` at the next edge, and `eff_code` returns to `active_code`.
- R10: A count value of 0 expires after exactly one tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wd_enable | input | 1 | Arms the watchdog; 0 holds it idle and clears the alarm |
| count_value | input | CNT_W | Timeout in ticks, minus one |
| count_wr | input | 1 | Strobe: the count value was written; restarts the timeout |
| tb_sel | input | 1 | Tick period select: 0 slow, 1 fast |
| safe_code | input | CODE_W | Fallback frequency-select code |
| active_code | input | CODE_W | Frequency-select code in normal operation |
| service | input | 1 | Strobe: a valid host transaction took place; restarts the timeout |
| eff_code | output | CODE_W | Frequency-select code actually applied |
| alarm | output | 1 | Sticky timeout status, 1 means alarm |

## Verification
The hardest situation to reach is a restart that lands between two ticks. The bench must then confirm that the whole timeout is measured again from that edge, and not from the old tick phase. The stimulus issues a second service pulse part-way through a slow-timebase countdown. It then expects the alarm on exactly the edge computed from the second pulse. The bench also confirms, at the outputs, that an alarm once raised survives service and count writes and ignores changes to the active code.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    parameter int unsigned WDG_CNT_W  = 8;
    parameter int unsigned WDG_CODE_W = 5;

    typedef enum logic {
        TB_SLOW = 1'b0,
        TB_FAST = 1'b1
    } wdg_tb_e;
endpackage

// File: rtl/wdg_tick_gen.sv
module wdg_tick_gen #(
    parameter int unsigned SLOW_TICK_CLKS = 580,
    parameter int unsigned FAST_TICK_CLKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic restart,
    input  logic tb_sel,
    output logic tick
);
    import wdg_pkg::*;

    localparam int unsigned MAXP = (SLOW_TICK_CLKS > FAST_TICK_CLKS) ? SLOW_TICK_CLKS : FAST_TICK_CLKS;
    localparam int unsigned PW   = $clog2(MAXP + 1);
    localparam logic [PW-1:0] SLOW_M1 = PW'(SLOW_TICK_CLKS - 1);
    localparam logic [PW-1:0] FAST_M1 = PW'(FAST_TICK_CLKS - 1);

    typedef struct packed {
        logic [PW-1:0] pre;
    } tick_st_t;

    tick_st_t st_d, st_q;
    logic [PW-1:0] limit;
    logic          clr;

    always_comb begin
        st_d  = st_q;
        limit = (wdg_tb_e'(tb_sel) == TB_FAST) ? FAST_M1 : SLOW_M1;
        clr   = !en || restart;
        tick  = 1'b0;
        if (clr) begin
            st_d.pre = '0;
        end else if (st_q.pre >= limit) begin
            st_d.pre = '0;
            tick     = 1'b1;
        end else begin
            st_d.pre = st_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/wdg_countdown.sv
module wdg_countdown #(
    parameter int unsigned CNT_W = wdg_pkg::WDG_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             restart,
    input  logic             tick,
    input  logic [CNT_W-1:0] load_val,
    output logic             alarm
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             alarm;
    } cd_st_t;

    cd_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d.cnt   = load_val;
            st_d.alarm = 1'b0;
        end else if (st_q.alarm) begin
            st_d = st_q;
        end else if (restart) begin
            st_d.cnt = load_val;
        end else if (tick) begin
            if (st_q.cnt == '0) st_d.alarm = 1'b1;
            else                st_d.cnt   = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt   <= '1;
            st_q.alarm <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign alarm = st_q.alarm;

    // R3
    expiry_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.alarm) |-> ($past(tick) && $past(st_q.cnt) == '0));

    // R5
    restart_holds_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && restart && !st_q.alarm) |=> !st_q.alarm);

    // R8
    alarm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && st_q.alarm) |=> st_q.alarm);

    // R9
    disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !st_q.alarm);
endmodule

// File: rtl/wdg_code_sel.sv
module wdg_code_sel #(
    parameter int unsigned CODE_W = wdg_pkg::WDG_CODE_W
) (
    input  logic              alarm,
    input  logic [CODE_W-1:0] safe_code,
    input  logic [CODE_W-1:0] active_code,
    output logic [CODE_W-1:0] eff_code
);
    always_comb begin
        eff_code = alarm ? safe_code : active_code;
    end
endmodule

// File: rtl/ocwd_top.sv
module ocwd_top #(
    parameter int unsigned CNT_W          = wdg_pkg::WDG_CNT_W,
    parameter int unsigned CODE_W         = wdg_pkg::WDG_CODE_W,
    parameter int unsigned SLOW_TICK_CLKS = 580,
    parameter int unsigned FAST_TICK_CLKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wd_enable,
    input  logic [CNT_W-1:0]  count_value,
    input  logic              count_wr,
    input  logic              tb_sel,
    input  logic [CODE_W-1:0] safe_code,
    input  logic [CODE_W-1:0] active_code,
    input  logic              service,
    output logic [CODE_W-1:0] eff_code,
    output logic              alarm
);
    logic restart;
    logic tick;

    assign restart = service || count_wr;

    wdg_tick_gen #(
        .SLOW_TICK_CLKS(SLOW_TICK_CLKS),
        .FAST_TICK_CLKS(FAST_TICK_CLKS)
    ) tick_i (
        .clk(clk), .rst_n(rst_n), .en(wd_enable),
        .restart(restart), .tb_sel(tb_sel), .tick(tick)
    );

    wdg_countdown #(.CNT_W(CNT_W)) cd_i (
        .clk(clk), .rst_n(rst_n), .en(wd_enable),
        .restart(restart), .tick(tick), .load_val(count_value),
        .alarm(alarm)
    );

    wdg_code_sel #(.CODE_W(CODE_W)) sel_i (
        .alarm(alarm), .safe_code(safe_code),
        .active_code(active_code), .eff_code(eff_code)
    );

    // R2
    idle_no_alarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wd_enable && !alarm) |=> !alarm);
endmodule

// File: tb/ocwd_top_tb.sv
module ocwd_top_tb_top;
    localparam int SLOW = 6;
    localparam int FAST = 3;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       wd_enable = 0;
    logic [7:0] count_value = 8'hFF;
    logic       count_wr = 0;
    logic       tb_sel = 0;
    logic [4:0] safe_code = 5'h00;
    logic [4:0] active_code = 5'h13;
    logic       service = 0;
    logic [4:0] eff_code;
    logic       alarm;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ocwd_top #(.SLOW_TICK_CLKS(SLOW), .FAST_TICK_CLKS(FAST)) dut_i (
        .clk(clk), .rst_n(rst_n), .wd_enable(wd_enable),
        .count_value(count_value), .count_wr(count_wr), .tb_sel(tb_sel),
        .safe_code(safe_code), .active_code(active_code), .service(service),
        .eff_code(eff_code), .alarm(alarm)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // starts at a negedge; leaves the bench at the negedge after restart edge k
    task automatic arm(int n, bit fast);
        @(negedge clk);
        wd_enable = 0; count_value = 8'(n); tb_sel = fast;
        @(negedge clk);
        wd_enable = 1; service = 1;
        @(posedge clk);
        @(negedge clk);
        service = 0;
    endtask

    task automatic pulse_service();
        service = 1;
        @(posedge clk);
        @(negedge clk);
        service = 0;
    endtask

    task automatic wait_expire(int t, string req);
        for (int i = 1; i <= t; i++) begin
            @(negedge clk);
            if (i == t - 1) chk(req, alarm, 0);
            if (i == t)     chk(req, alarm, 1);
        end
    endtask

    task automatic disarm();
        @(negedge clk);
        wd_enable = 0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 alarm", alarm, 0);
        chk("R1 code", eff_code, 5'h13);
    endtask

    task automatic t_disabled();
        @(negedge clk);
        wd_enable = 0; count_value = 8'd2; tb_sel = 0;
        repeat (500) @(negedge clk);
        chk("R2 alarm", alarm, 0);
        chk("R2 code", eff_code, 5'h13);
    endtask

    task automatic t_slow();
        safe_code = 5'h05;
        arm(3, 0);
        wait_expire(4 * SLOW, "R3");
        chk("R7 code", eff_code, 5'h05);
        active_code = 5'h1E;
        @(negedge clk);
        chk("R7 active ignored", eff_code, 5'h05);
        pulse_service();
        count_value = 8'd9; count_wr = 1;
        @(negedge clk);
        count_wr = 0;
        repeat (50) @(negedge clk);
        chk("R8 alarm", alarm, 1);
        chk("R8 code", eff_code, 5'h05);
        wd_enable = 0;
        @(negedge clk);
        chk("R9 alarm", alarm, 0);
        chk("R9 code", eff_code, 5'h1E);
    endtask

    task automatic t_fast();
        arm(4, 1);
        wait_expire(5 * FAST, "R4");
        disarm();
    endtask

    task automatic t_service();
        arm(2, 0);
        repeat (10) @(negedge clk);
        chk("R5 before", alarm, 0);
        pulse_service();
        wait_expire(3 * SLOW, "R5");
        disarm();
    endtask

    task automatic t_countwr();
        arm(200, 0);
        repeat (7) @(negedge clk);
        count_value = 8'd1; count_wr = 1;
        @(posedge clk);
        @(negedge clk);
        count_wr = 0;
        wait_expire(2 * SLOW, "R6");
        disarm();
    endtask

    task automatic t_zero();
        arm(0, 0);
        wait_expire(SLOW, "R10");
        disarm();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_slow();
        t_fast();
        t_service();
        t_countwr();
        t_zero();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog timeout actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule